// File: doc/BRIEF.md
# Command Token Scheduler with Return Tracking

This block is the issuing side of a ring of DMA slave modules. Host CPUs post data requests as bits in a request array. The block picks one pending requester with a rotating priority encoder and builds a 64-bit command token. The token carries the requester's 12-bit identifier and the next event-buffer address, which advances by one for every token. The token goes into the ring only when the outgoing heartbeat offers a free slot. Each slave in the ring adds one to the token's done counter on its way round, so a token that comes back carries a count equal to the number of slaves.

Every token in flight holds an entry in a scoreboard of at most 16 entries. The entry's index travels inside the token. When the token comes back, its done count is compared with the configured slave count and the entry is released. An entry whose token stays away longer than a programmable number of cycles is freed and reported. New tokens stop while the host holds its throttle input, while a slave's hold message is in force, or while the scoreboard is full. Errors raise an interrupt with an 8-bit code that stays frozen until the host clears it.

Top module: `xfer_cmd_sched`

## Requirements
- R1: After a synchronous reset, `tok_valid`, `irq` and `irq_code` are all 0.
- R2: A token is issued when `slot_free` is 1, a request is pending, no throttle is active and the scoreboard is not full. `tok_valid` is then 1 in the following cycle. The token has class bits [63:62]=01 and kind bits [61:60]=00, the identifier in [40:29] and the scoreboard index in [28:25]. The index is the lowest free entry.
- R3: The buffer address in bits [51:41] is 0 for the first token after reset and rises by one with each token issued.
- R4: Bit [59] is 1 on the first token after reset and 0 on every later token.
- R5: The identifier served is the request-array bit position. The search starts one position past the last served CPU, wraps round, and takes the lowest set bit from there. Right after reset it starts at bit 0. A served bit is cleared from the array.
- R6: With `slot_free` at 0, no token is issued and requests stay pending.
- R7: `host_throttle` at 1 blocks issue. A returning token with class 10, kind 11 and opcode [24:22]=100 blocks issue until a like token with opcode 110 arrives. Neither message raises an interrupt.
- R8: With 16 tokens outstanding, issue stalls. It resumes the cycle after an entry is freed.
- R9: A returning token with class 01 and kind 00, whose done count [58:52] equals `cfg_slaves`, frees its entry and raises no interrupt.
- R10: A returning command token whose done count differs from `cfg_slaves` frees its entry and sets `irq_code` = {4'h1, index}.
- R11: An entry outstanding for `cfg_timeout` cycles is freed and sets `irq_code` = {4'h2, index}. A later return of that token then counts as stray.
- R12: A returning token with class 10, kind 11 and opcode 001 sets `irq_code` = {4'h3, info[3:0]}, where info sits in bits [21:15].
- R13: A returning command token for an entry that is not busy sets `irq_code` = {4'h4, index}. While `irq` is 1 the code is frozen, and `irq_clr` returns both `irq` and `irq_code` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_set | input | NUM_CPU | Pulses that set bits of the request array |
| slot_free | input | 1 | Outgoing heartbeat slot is empty this cycle |
| host_throttle | input | 1 | Host hold on new tokens |
| cfg_slaves | input | 7 | Number of slaves in the ring |
| cfg_timeout | input | TMO_W | Cycles allowed for a token to return |
| ret_valid | input | 1 | A token is arriving from the ring |
| ret_tok | input | 64 | The arriving token |
| irq_clr | input | 1 | Clears the interrupt and its code |
| tok_valid | output | 1 | A command token is on `tok_out` |
| tok_out | output | 64 | Outgoing command token |
| irq | output | 1 | Interrupt pending |
| irq_code | output | 8 | Cause in [7:4], index or info in [3:0] |

## Verification
The embedded properties assume that at most one token returns per cycle. They also assume that `irq_clr` is never raised in the same cycle as a new error, and that the index in a returning token is below the scoreboard depth. The stimulus drives one return at a time and clears the interrupt only in quiet cycles. Every returned token is built from one the block actually issued, so indices stay in range. The timeout in the window under test is set small, and it stays large during the fill and throttle phases, so that no stray expiry lands in a check.

// File: rtl/xcs_pkg.sv
package xcs_pkg;
    localparam int TOK_W  = 64;
    localparam int ADDR_W = 11;
    localparam int ID_W   = 12;
    localparam int DONE_W = 7;
    localparam int SLOT_W = 4;
    localparam int INFO_W = 7;
    localparam int CODE_W = 8;

    typedef enum logic [1:0] {
        CLS_EMPTY    = 2'b00,
        CLS_CMD      = 2'b01,
        CLS_TO_SCHED = 2'b10,
        CLS_SPARE    = 2'b11
    } cls_e;

    typedef enum logic [1:0] {
        KIND_CMD = 2'b00,
        KIND_ALL = 2'b01,
        KIND_ONE = 2'b10,
        KIND_UP  = 2'b11
    } kind_e;

    localparam logic [2:0] OP_ERROR  = 3'b001;
    localparam logic [2:0] OP_HOLD   = 3'b100;
    localparam logic [2:0] OP_RESUME = 3'b110;

    typedef enum logic [3:0] {
        CAUSE_NONE    = 4'h0,
        CAUSE_BAD_CNT = 4'h1,
        CAUSE_TIMEOUT = 4'h2,
        CAUSE_SLAVE   = 4'h3,
        CAUSE_STRAY   = 4'h4
    } cause_e;

    typedef struct packed {
        cls_e               cls;
        kind_e              kind;
        logic               first;
        logic [DONE_W-1:0]  done;
        logic [ADDR_W-1:0]  buf_addr;
        logic [ID_W-1:0]    cpu_id;
        logic [SLOT_W-1:0]  slot;
        logic [2:0]         op;
        logic [INFO_W-1:0]  info;
        logic [14:0]        spare;
    } tok_t;

    function automatic tok_t make_cmd(input logic              first,
                                      input logic [ADDR_W-1:0] addr,
                                      input logic [ID_W-1:0]   id,
                                      input logic [SLOT_W-1:0] slot);
        tok_t t;
        t          = '0;
        t.cls      = CLS_CMD;
        t.kind     = KIND_CMD;
        t.first    = first;
        t.buf_addr = addr;
        t.cpu_id   = id;
        t.slot     = slot;
        return t;
    endfunction
endpackage

// File: rtl/xcs_arbiter.sv
module xcs_arbiter #(
    parameter int N = 16,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N-1:0]  req_set,
    input  logic          take,
    output logic          any,
    output logic [IW-1:0] pick
);
    logic [N-1:0]  pend;
    logic [N-1:0]  pick_oh;
    logic [IW-1:0] start;
    logic [IW:0]   pos;

    // rotating search: first set bit at or after start, wrapping
    always_comb begin
        any  = 1'b0;
        pick = '0;
        pos  = '0;
        for (int i = 0; i < N; i++) begin
            pos = {1'b0, start} + (IW+1)'(i);
            if (pos >= (IW+1)'(N)) pos = pos - (IW+1)'(N);
            if (!any && pend[pos[IW-1:0]]) begin
                any  = 1'b1;
                pick = pos[IW-1:0];
            end
        end
    end

    always_comb begin
        pick_oh = '0;
        if (any) pick_oh[pick] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend  <= '0;
            start <= '0;
        end else begin
            pend <= (pend | req_set) & ~(take ? pick_oh : '0);
            if (take) start <= (pick == IW'(N-1)) ? '0 : pick + 1'b1;
        end
    end

    // R5: the top only takes when a request is pending
    assert_take_pending_R5: assert property (@(posedge clk) disable iff (rst)
        take |-> any);
    // R5: a served bit leaves the array unless set again
    assert_served_cleared_R5: assert property (@(posedge clk) disable iff (rst)
        (take && !req_set[pick]) |=> !pend[$past(pick)]);
endmodule

// File: rtl/xcs_scoreboard.sv
module xcs_scoreboard #(
    parameter int DEPTH = 16,
    parameter int TMO_W = 16,
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             alloc,
    input  logic             clr,
    input  logic [IW-1:0]    clr_idx,
    input  logic [TMO_W-1:0] limit,
    output logic             full,
    output logic [IW-1:0]    free_idx,
    output logic             busy_at_clr,
    output logic             expire_any,
    output logic [IW-1:0]    expire_idx
);
    logic [DEPTH-1:0] busy;
    logic [DEPTH-1:0] expire;

    for (genvar e = 0; e < DEPTH; e++) begin : g_entry
        logic             b_q;
        logic [TMO_W-1:0] age_q;

        assign busy[e]   = b_q;
        assign expire[e] = b_q && (age_q == limit - 1'b1);

        always_ff @(posedge clk) begin
            if (rst) begin
                b_q   <= 1'b0;
                age_q <= '0;
            end else if (alloc && !full && free_idx == IW'(e)) begin
                b_q   <= 1'b1;
                age_q <= '0;
            end else if ((clr && clr_idx == IW'(e)) || expire[e]) begin
                b_q   <= 1'b0;
                age_q <= '0;
            end else if (b_q) begin
                age_q <= age_q + 1'b1;
            end
        end
    end

    always_comb begin
        free_idx = '0;
        for (int e = DEPTH - 1; e >= 0; e--)
            if (!busy[e]) free_idx = IW'(e);
    end

    always_comb begin
        expire_idx = '0;
        for (int e = DEPTH - 1; e >= 0; e--)
            if (expire[e]) expire_idx = IW'(e);
    end

    assign full        = &busy;
    assign busy_at_clr = busy[clr_idx];
    assign expire_any  = |expire;

    // R8: the issuer never allocates into a full scoreboard
    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
        alloc |-> !full);
    // R9: a returning token releases its entry
    assert_return_frees_R9: assert property (@(posedge clk) disable iff (rst)
        (clr && busy_at_clr) |=> !busy[$past(clr_idx)]);
endmodule

// File: rtl/xcs_return_decode.sv
module xcs_return_decode
    import xcs_pkg::*;
(
    input  logic              valid,
    input  logic [TOK_W-1:0]  word,
    input  logic [DONE_W-1:0] slaves,
    output logic              cmd_back,
    output logic              done_ok,
    output logic [SLOT_W-1:0] slot,
    output logic              err_msg,
    output logic              hold_msg,
    output logic              resume_msg,
    output logic [3:0]        info_lo
);
    tok_t w;
    logic up;
    logic unused_bits;

    assign w          = tok_t'(word);
    assign cmd_back   = valid && w.cls == CLS_CMD && w.kind == KIND_CMD;
    assign up         = valid && w.cls == CLS_TO_SCHED && w.kind == KIND_UP;
    assign done_ok    = (w.done == slaves);
    assign slot       = w.slot;
    assign err_msg    = up && w.op == OP_ERROR;
    assign hold_msg   = up && w.op == OP_HOLD;
    assign resume_msg = up && w.op == OP_RESUME;
    assign info_lo    = w.info[3:0];
    assign unused_bits = ^{w.first, w.buf_addr, w.cpu_id, w.info[6:4], w.spare};
endmodule

// File: rtl/xfer_cmd_sched.sv
module xfer_cmd_sched
    import xcs_pkg::*;
#(
    parameter int NUM_CPU = 16,
    parameter int DEPTH   = 16,
    parameter int TMO_W   = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_CPU-1:0] req_set,
    input  logic               slot_free,
    input  logic               host_throttle,
    input  logic [DONE_W-1:0]  cfg_slaves,
    input  logic [TMO_W-1:0]   cfg_timeout,
    input  logic               ret_valid,
    input  logic [TOK_W-1:0]   ret_tok,
    input  logic               irq_clr,
    output logic               tok_valid,
    output logic [TOK_W-1:0]   tok_out,
    output logic               irq,
    output logic [CODE_W-1:0]  irq_code
);
    localparam int CPU_IW = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1;
    localparam int IW     = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic              any_req;
    logic [CPU_IW-1:0] pick;
    logic              issue;
    logic              full;
    logic [IW-1:0]     free_idx;
    logic              busy_at_clr;
    logic              expire_any;
    logic [IW-1:0]     expire_idx;
    logic              cmd_back, done_ok, err_msg, hold_msg, resume_msg;
    logic [SLOT_W-1:0] ret_slot;
    logic [3:0]        info_lo;
    logic              slave_hold;
    logic              first_pend;
    logic [ADDR_W-1:0] next_addr;
    tok_t              out_q;
    cause_e            cause;
    logic [3:0]        detail;

    assign issue = slot_free && any_req && !host_throttle && !slave_hold && !full;

    xcs_arbiter #(.N(NUM_CPU)) u_arb (
        .clk     (clk),
        .rst     (rst),
        .req_set (req_set),
        .take    (issue),
        .any     (any_req),
        .pick    (pick)
    );

    xcs_return_decode u_dec (
        .valid      (ret_valid),
        .word       (ret_tok),
        .slaves     (cfg_slaves),
        .cmd_back   (cmd_back),
        .done_ok    (done_ok),
        .slot       (ret_slot),
        .err_msg    (err_msg),
        .hold_msg   (hold_msg),
        .resume_msg (resume_msg),
        .info_lo    (info_lo)
    );

    xcs_scoreboard #(.DEPTH(DEPTH), .TMO_W(TMO_W)) u_sb (
        .clk         (clk),
        .rst         (rst),
        .alloc       (issue),
        .clr         (cmd_back),
        .clr_idx     (IW'(ret_slot)),
        .limit       (cfg_timeout),
        .full        (full),
        .free_idx    (free_idx),
        .busy_at_clr (busy_at_clr),
        .expire_any  (expire_any),
        .expire_idx  (expire_idx)
    );

    // error source selection: return-path errors win over expiry
    always_comb begin
        cause  = CAUSE_NONE;
        detail = '0;
        if (cmd_back && !busy_at_clr) begin
            cause  = CAUSE_STRAY;
            detail = 4'(ret_slot);
        end else if (cmd_back && !done_ok) begin
            cause  = CAUSE_BAD_CNT;
            detail = 4'(ret_slot);
        end else if (err_msg) begin
            cause  = CAUSE_SLAVE;
            detail = info_lo;
        end else if (expire_any) begin
            cause  = CAUSE_TIMEOUT;
            detail = 4'(expire_idx);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tok_valid  <= 1'b0;
            out_q      <= '0;
            next_addr  <= '0;
            first_pend <= 1'b1;
            slave_hold <= 1'b0;
            irq        <= 1'b0;
            irq_code   <= '0;
        end else begin
            tok_valid <= issue;
            out_q     <= issue ? make_cmd(first_pend, next_addr, ID_W'(pick), SLOT_W'(free_idx))
                               : '0;
            if (issue) begin
                next_addr  <= next_addr + 1'b1;
                first_pend <= 1'b0;
            end
            if (resume_msg)    slave_hold <= 1'b0;
            else if (hold_msg) slave_hold <= 1'b1;
            if (irq_clr) begin
                irq      <= 1'b0;
                irq_code <= '0;
            end else if (!irq && cause != CAUSE_NONE) begin
                irq      <= 1'b1;
                irq_code <= {cause, detail};
            end
        end
    end

    assign tok_out = out_q;

    // R6: no heartbeat slot, no token
    assert_slot_gate_R6: assert property (@(posedge clk) disable iff (rst)
        !slot_free |=> !tok_valid);
    // R7: either throttle source suppresses issue
    assert_throttle_gate_R7: assert property (@(posedge clk) disable iff (rst)
        (host_throttle || slave_hold) |=> !tok_valid);
    // R13: a pending code is frozen until cleared
    assert_code_hold_R13: assert property (@(posedge clk) disable iff (rst)
        (irq && !irq_clr) |=> (irq && $stable(irq_code)));
    // R4: the first-token flag never reappears once a token has gone out
    assert_first_once_R4: assert property (@(posedge clk) disable iff (rst)
        (tok_valid && !tok_out[59]) |-> !first_pend);
endmodule

// File: tb/xfer_cmd_sched_bench.sv
module xfer_cmd_sched_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] req_set;
    logic        slot_free, host_throttle, ret_valid, irq_clr;
    logic [6:0]  cfg_slaves;
    logic [15:0] cfg_timeout;
    logic [63:0] ret_tok;
    logic        tok_valid, irq;
    logic [63:0] tok_out;
    logic [7:0]  irq_code;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    xfer_cmd_sched u_xfer_cmd_sched (
        .clk(clk), .rst(rst), .req_set(req_set), .slot_free(slot_free),
        .host_throttle(host_throttle), .cfg_slaves(cfg_slaves),
        .cfg_timeout(cfg_timeout), .ret_valid(ret_valid), .ret_tok(ret_tok),
        .irq_clr(irq_clr), .tok_valid(tok_valid), .tok_out(tok_out),
        .irq(irq), .irq_code(irq_code)
    );

    // {request mask, expected served identifier}
    localparam logic [19:0] VEC [9] = '{
        {16'h0001, 4'd0},  {16'h8004, 4'd2}, {16'h0002, 4'd15},
        {16'h0000, 4'd1},  {16'h0030, 4'd4}, {16'h0011, 4'd5},
        {16'h0000, 4'd0},  {16'h0800, 4'd4}, {16'h0000, 4'd11}
    };

    task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic issue_one(input logic [15:0] m, output logic [63:0] t, output logic v);
        req_set = m;
        tick();
        req_set   = '0;
        slot_free = 1'b1;
        tick();
        slot_free = 1'b0;
        t = tok_out;
        v = tok_valid;
    endtask

    task automatic give_back(input logic [63:0] t);
        ret_valid = 1'b1;
        ret_tok   = t;
        tick();
        ret_valid = 1'b0;
        ret_tok   = '0;
    endtask

    task automatic clear_irq();
        irq_clr = 1'b1;
        tick();
        irq_clr = 1'b0;
    endtask

    function automatic logic [63:0] with_done(input logic [63:0] t, input logic [6:0] d);
        logic [63:0] r;
        r = t;
        r[58:52] = d;
        return r;
    endfunction

    function automatic logic [63:0] msg(input logic [2:0] op, input logic [6:0] info);
        logic [63:0] r;
        r = '0;
        r[63:62] = 2'b10;
        r[61:60] = 2'b11;
        r[24:22] = op;
        r[21:15] = info;
        return r;
    endfunction

    initial begin
        logic [63:0] t;
        logic [63:0] extra;
        logic        v;
        logic [63:0] held [16];
        int          got;

        rst = 1'b1; req_set = '0; slot_free = 1'b0; host_throttle = 1'b0;
        ret_valid = 1'b0; ret_tok = '0; irq_clr = 1'b0;
        cfg_slaves = 7'd5; cfg_timeout = 16'd1000;
        repeat (3) tick();
        rst = 1'b0;
        tick();
        chk("R1 tok_valid after reset", tok_valid, 0);
        chk("R1 irq after reset", irq, 0);
        chk("R1 irq_code after reset", irq_code, 0);

        // table walk: rotation, address advance, first flag, clean returns
        for (int i = 0; i < 9; i++) begin
            issue_one(VEC[i][19:4], t, v);
            chk("R2 token valid", v, 1);
            chk("R2 class and kind", t[63:60], 4'b0100);
            chk("R5 served identifier", t[40:29], VEC[i][3:0]);
            chk("R3 buffer address", t[51:41], i);
            chk("R4 first flag", t[59], (i == 0));
            chk("R2 scoreboard index", t[28:25], 0);
            give_back(with_done(t, 7'd5));
            chk("R9 clean return no irq", irq, 0);
        end

        // R6: hold off the slot
        req_set = 16'h0008;
        tick();
        req_set = '0;
        for (int k = 0; k < 3; k++) begin
            tick();
            chk("R6 no slot no token", tok_valid, 0);
        end
        slot_free = 1'b1;
        tick();
        slot_free = 1'b0;
        chk("R6 pending request issued later", tok_valid, 1);
        chk("R6 identifier kept", tok_out[40:29], 3);
        chk("R3 address continues", tok_out[51:41], 9);
        give_back(with_done(tok_out, 7'd5));

        // R7: host throttle
        host_throttle = 1'b1;
        req_set = 16'h0040;
        tick();
        req_set = '0;
        slot_free = 1'b1;
        for (int k = 0; k < 3; k++) begin
            tick();
            chk("R7 host throttle blocks", tok_valid, 0);
        end
        host_throttle = 1'b0;
        tick();
        slot_free = 1'b0;
        chk("R7 release issues", tok_valid, 1);
        chk("R7 released identifier", tok_out[40:29], 6);
        give_back(with_done(tok_out, 7'd5));

        // R7: slave hold and resume messages
        give_back(msg(3'b100, 7'h0));
        req_set = 16'h0100;
        tick();
        req_set = '0;
        slot_free = 1'b1;
        for (int k = 0; k < 3; k++) begin
            tick();
            chk("R7 slave hold blocks", tok_valid, 0);
        end
        slot_free = 1'b0;
        give_back(msg(3'b110, 7'h0));
        chk("R7 messages raise no irq", irq, 0);
        issue_one(16'h0000, t, v);
        chk("R7 resume issues", v, 1);
        chk("R7 resumed identifier", t[40:29], 8);
        give_back(with_done(t, 7'd5));

        // R8: fill the scoreboard
        req_set = 16'hFFFF;
        tick();
        req_set = '0;
        slot_free = 1'b1;
        got = 0;
        for (int k = 0; k < 16; k++) begin
            tick();
            if (tok_valid) begin
                held[got] = tok_out;
                got++;
            end
        end
        chk("R8 sixteen outstanding", got, 16);
        chk("R5 rotation resumes past last served", held[0][40:29], 9);
        chk("R2 lowest free index", held[5][28:25], 5);
        req_set = 16'h0001;
        for (int k = 0; k < 3; k++) begin
            tick();
            req_set = '0;
            chk("R8 full stalls issue", tok_valid, 0);
        end
        give_back(with_done(held[5], 7'd5));
        tick();
        slot_free = 1'b0;
        chk("R8 issue after free", tok_valid, 1);
        chk("R8 reused index", tok_out[28:25], 5);
        chk("R8 waiting identifier", tok_out[40:29], 0);
        extra = tok_out;
        for (int k = 0; k < 16; k++)
            if (k != 5) give_back(with_done(held[k], 7'd5));
        give_back(with_done(extra, 7'd5));
        chk("R9 bulk returns no irq", irq, 0);

        // R10 and R13
        issue_one(16'h0002, t, v);
        give_back(with_done(t, 7'd4));
        chk("R10 bad count irq", irq, 1);
        chk("R10 bad count code", irq_code, 8'h10);
        give_back(with_done(t, 7'd5));
        chk("R13 code frozen while pending", irq_code, 8'h10);
        clear_irq();
        chk("R13 clear irq", irq, 0);
        chk("R13 clear code", irq_code, 0);
        give_back(with_done(t, 7'd5));
        chk("R13 stray return code", irq_code, 8'h40);
        clear_irq();

        // R12
        give_back(msg(3'b001, 7'h25));
        chk("R12 slave error irq", irq, 1);
        chk("R12 slave error code", irq_code, 8'h35);
        clear_irq();

        // R11
        cfg_timeout = 16'd20;
        issue_one(16'h0004, t, v);
        repeat (19) tick();
        chk("R11 no irq before limit", irq, 0);
        tick();
        chk("R11 timeout irq", irq, 1);
        chk("R11 timeout code", irq_code, 8'h20);
        clear_irq();
        give_back(with_done(t, 7'd5));
        chk("R11 expired entry freed", irq_code, 8'h40);
        clear_irq();

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule